// File: doc/BRIEF.md
# CSR Access Legality Checker

This block sits next to a machine-mode control and status register file in a RISC-V core. For each access it receives the 12-bit register address, a read strobe, a write strobe and a flag that shows whether the hart is in debug mode. In the same cycle it decides whether the access is legal. It raises `access_ok` only when at least one strobe is active and every requested direction is permitted. A rejected access produces a registered single-cycle `trap_pulse`. With that pulse the block loads the illegal-instruction cause code and the offending address into holding registers for the trap unit.

Each address falls into one of four classes. Identification registers, user counter shadows and the trigger select register can be read but not written. Machine registers and the machine counters can be read and written. Debug registers can be reached only in debug mode. Every other address is not implemented. Whether an access is legal depends on both the class and the direction of the access. Performance counter decoding is generated from the parameterised counter range.

Top module: `csr_access_guard`

## Requirements
- R1: A read of 0xF11 to 0xF15 is accepted. A write to any of these addresses is rejected.
- R2: A read of 0xC00, 0xC02, 0xC80 or 0xC82 is accepted. A write to any of them is rejected.
- R3: At 0x7A0 a read is accepted and a write is rejected. At 0x7A1, 0x302 and 0x303 both reads and writes are rejected.
- R4: Reads and writes are accepted at 0x300, 0x301, 0x304, 0x305, 0x310, 0x320, 0x323, 0x340, 0x341, 0x342, 0x343 and 0x344.
- R5: Reads and writes are accepted at 0xB00, 0xB02, 0xB80 and 0xB82. They are also accepted at every performance counter 0xB03 to 0xB1F and its upper half 0xB83 to 0xB9F.
- R6: At 0x7B0, 0x7B1 and 0xBFF, reads and writes are rejected while `dbg_mode` is 0 and accepted while it is 1.
- R7: At 0x7B2 and 0x7B3 reads and writes are rejected whatever the value of `dbg_mode`.
- R8: Any address not listed in R1 to R7 is rejected for both reads and writes.
- R9: When read and write are both asserted, the access is accepted only if both directions are legal. If either is illegal, exactly one trap pulse follows.
- R10: `access_ok` is combinational in the cycle of the access and is 0 when no strobe is active. `trap_pulse` is 1 for exactly the cycle after a rejected access. It is 0 after an accepted access or a cycle with no access.
- R11: When a trap occurs, `trap_cause` becomes 2 and `trap_addr` becomes the rejected address, both in the same cycle as the pulse. Both values hold until the next trap. Reset clears them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 12 | Address of the register being accessed |
| rd_en | input | 1 | Access reads the register |
| wr_en | input | 1 | Access writes the register |
| dbg_mode | input | 1 | Hart is in debug mode |
| access_ok | output | 1 | Access is legal (combinational) |
| trap_pulse | output | 1 | One-cycle pulse after a rejected access |
| trap_cause | output | CAUSE_W | Cause code captured at the last trap |
| trap_addr | output | 12 | Address captured at the last trap |

## Verification
`access_ok` is due in the same cycle as the stimulus. The bench therefore drives inputs on a falling edge and samples `access_ok` 1 ns later, before any rising edge. `trap_pulse`, `trap_cause` and `trap_addr` change at the first rising edge after the access, so they are checked at the next falling edge, once the strobes are removed. One more falling edge later the bench checks that the pulse has dropped and that the captured values stay the same while only legal accesses follow.

// File: rtl/csr_guard_pkg.sv
package csr_guard_pkg;

  localparam int CSR_AW = 12;
  typedef logic [CSR_AW-1:0] csr_addr_t;

  // Access class of a register address
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,   // not implemented: always rejected
    ACC_RO   = 2'd1,   // readable, never writable
    ACC_RW   = 2'd2,   // readable and writable
    ACC_DBG  = 2'd3    // read/write only while in debug mode
  } acc_class_e;

  // Read-only identification window
  localparam csr_addr_t ID_LO       = 12'hF11;
  localparam csr_addr_t ID_HI       = 12'hF15;
  // User counter shadows
  localparam csr_addr_t UCYC_LO     = 12'hC00;
  localparam csr_addr_t UINS_LO     = 12'hC02;
  localparam csr_addr_t UCYC_HI     = 12'hC80;
  localparam csr_addr_t UINS_HI     = 12'hC82;
  // Trigger select (readable only)
  localparam csr_addr_t TRIG_SEL    = 12'h7A0;
  // Machine trap setup/handling registers
  localparam csr_addr_t M_STAT      = 12'h300;
  localparam csr_addr_t M_ISA       = 12'h301;
  localparam csr_addr_t M_IEN       = 12'h304;
  localparam csr_addr_t M_VEC       = 12'h305;
  localparam csr_addr_t M_STATH     = 12'h310;
  localparam csr_addr_t M_CNTINH    = 12'h320;
  localparam csr_addr_t M_EVT3      = 12'h323;
  localparam csr_addr_t M_SCR       = 12'h340;
  localparam csr_addr_t M_EPC       = 12'h341;
  localparam csr_addr_t M_CAUSE     = 12'h342;
  localparam csr_addr_t M_TVAL      = 12'h343;
  localparam csr_addr_t M_IPEND     = 12'h344;
  // Machine counters: low and high half bases
  localparam csr_addr_t MCNT_LO_BASE = 12'hB00;
  localparam csr_addr_t MCNT_HI_BASE = 12'hB80;
  localparam csr_addr_t MCYC_LO     = 12'hB00;
  localparam csr_addr_t MINS_LO     = 12'hB02;
  localparam csr_addr_t MCYC_HI     = 12'hB80;
  localparam csr_addr_t MINS_HI     = 12'hB82;
  // Debug-mode registers
  localparam csr_addr_t DBG_CTRL    = 12'h7B0;
  localparam csr_addr_t DBG_PC      = 12'h7B1;
  localparam csr_addr_t DBG_MBOX    = 12'hBFF;

  // True when the address lies in the identification window
  function automatic logic in_id_window(input csr_addr_t a);
    return (a >= ID_LO) && (a <= ID_HI);
  endfunction

  // Class of every fixed (non-generated) address
  function automatic acc_class_e fixed_class(input csr_addr_t a);
    acc_class_e c;
    if (in_id_window(a)) begin
      c = ACC_RO;
    end else begin
      case (a)
        UCYC_LO, UINS_LO, UCYC_HI, UINS_HI, TRIG_SEL:
          c = ACC_RO;
        M_STAT, M_ISA, M_IEN, M_VEC, M_STATH, M_CNTINH, M_EVT3,
        M_SCR, M_EPC, M_CAUSE, M_TVAL, M_IPEND,
        MCYC_LO, MINS_LO, MCYC_HI, MINS_HI:
          c = ACC_RW;
        DBG_CTRL, DBG_PC, DBG_MBOX:
          c = ACC_DBG;
        default:
          c = ACC_NONE;
      endcase
    end
    return c;
  endfunction

  // Is a read of this class legal?
  function automatic logic read_legal(input acc_class_e c, input logic dbg);
    logic r;
    case (c)
      ACC_RO:  r = 1'b1;
      ACC_RW:  r = 1'b1;
      ACC_DBG: r = dbg;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  // Is a write of this class legal?
  function automatic logic write_legal(input acc_class_e c, input logic dbg);
    logic w;
    case (c)
      ACC_RW:  w = 1'b1;
      ACC_DBG: w = dbg;
      default: w = 1'b0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/csr_guard_decode.sv
module csr_guard_decode
  import csr_guard_pkg::*;
#(
  parameter int HPM_FIRST = 3,
  parameter int HPM_LAST  = 31
) (
  input  csr_addr_t  addr,
  output acc_class_e cls,
  output logic       hpm_hit
);

  localparam int NHPM = HPM_LAST - HPM_FIRST + 1;

  logic [NHPM-1:0] lo_hit;
  logic [NHPM-1:0] hi_hit;
  acc_class_e      base_cls;

  // One comparator pair per performance counter
  for (genvar i = 0; i < NHPM; i++) begin : g_hpm
    localparam csr_addr_t LO_ADDR = MCNT_LO_BASE + csr_addr_t'(HPM_FIRST + i);
    localparam csr_addr_t HI_ADDR = MCNT_HI_BASE + csr_addr_t'(HPM_FIRST + i);
    assign lo_hit[i] = (addr == LO_ADDR);
    assign hi_hit[i] = (addr == HI_ADDR);
  end

  assign hpm_hit  = (|lo_hit) | (|hi_hit);
  assign base_cls = fixed_class(addr);

  always_comb begin
    if (hpm_hit) cls = ACC_RW;
    else         cls = base_cls;
  end

endmodule

// File: rtl/csr_guard_judge.sv
module csr_guard_judge
  import csr_guard_pkg::*;
(
  input  acc_class_e cls,
  input  logic       rd_req,
  input  logic       wr_req,
  input  logic       dbg,
  output logic       rd_bad,
  output logic       wr_bad,
  output logic       reject,
  output logic       accept
);

  logic any_req;

  assign any_req = rd_req | wr_req;
  assign rd_bad  = rd_req & ~read_legal(cls, dbg);
  assign wr_bad  = wr_req & ~write_legal(cls, dbg);
  assign reject  = rd_bad | wr_bad;
  assign accept  = any_req & ~reject;

endmodule

// File: rtl/csr_guard_capture.sv
module csr_guard_capture
  import csr_guard_pkg::*;
#(
  parameter int CAUSE_W      = 5,
  parameter int ILLEGAL_CODE = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  csr_addr_t          fire_addr,
  output logic               pulse,
  output logic [CAUSE_W-1:0] cause,
  output csr_addr_t          addr_q
);

  localparam logic [CAUSE_W-1:0] CODE = CAUSE_W'(ILLEGAL_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse  <= 1'b0;
      cause  <= '0;
      addr_q <= '0;
    end else begin
      pulse <= fire;
      if (fire) begin
        cause  <= CODE;
        addr_q <= fire_addr;
      end
    end
  end

endmodule

// File: rtl/csr_access_guard.sv
module csr_access_guard
  import csr_guard_pkg::*;
#(
  parameter int CAUSE_W      = 5,
  parameter int ILLEGAL_CODE = 2,
  parameter int HPM_FIRST    = 3,
  parameter int HPM_LAST     = 31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [11:0]        csr_addr,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic               dbg_mode,
  output logic               access_ok,
  output logic               trap_pulse,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic [11:0]        trap_addr
);

  acc_class_e cls;
  logic       hpm_hit;
  logic       rd_bad;
  logic       wr_bad;
  logic       reject;

  csr_guard_decode #(
    .HPM_FIRST (HPM_FIRST),
    .HPM_LAST  (HPM_LAST)
  ) u_decode (
    .addr    (csr_addr),
    .cls     (cls),
    .hpm_hit (hpm_hit)
  );

  csr_guard_judge u_judge (
    .cls    (cls),
    .rd_req (rd_en),
    .wr_req (wr_en),
    .dbg    (dbg_mode),
    .rd_bad (rd_bad),
    .wr_bad (wr_bad),
    .reject (reject),
    .accept (access_ok)
  );

  csr_guard_capture #(
    .CAUSE_W      (CAUSE_W),
    .ILLEGAL_CODE (ILLEGAL_CODE)
  ) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (reject),
    .fire_addr (csr_addr),
    .pulse     (trap_pulse),
    .cause     (trap_cause),
    .addr_q    (trap_addr)
  );

endmodule

// File: rtl/csr_access_guard_chk.sv
module csr_access_guard_chk #(
  parameter int CAUSE_W      = 5,
  parameter int ILLEGAL_CODE = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [11:0]        csr_addr,
  input logic               rd_en,
  input logic               wr_en,
  input logic               dbg_mode,
  input logic               access_ok,
  input logic               trap_pulse,
  input logic [CAUSE_W-1:0] trap_cause,
  input logic [11:0]        trap_addr,
  input logic               rd_bad,
  input logic               wr_bad
);

  assert_ident_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && csr_addr >= 12'hF11 && csr_addr <= 12'hF15) |-> !access_ok);

  assert_ident_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && csr_addr >= 12'hF11 && csr_addr <= 12'hF15) |-> access_ok);

  assert_dbg_hidden_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_mode && (rd_en || wr_en) &&
     (csr_addr == 12'h7B0 || csr_addr == 12'h7B1 || csr_addr == 12'hBFF)) |-> !access_ok);

  assert_dscratch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && (csr_addr == 12'h7B2 || csr_addr == 12'h7B3)) |-> !access_ok);

  assert_both_dirs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_bad || wr_bad) |=> trap_pulse);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en || wr_en) |-> !access_ok);

  assert_pulse_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |-> ($past(rd_en || wr_en) && !$past(access_ok)));

  assert_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |-> (trap_cause == CAUSE_W'(ILLEGAL_CODE)));

  assert_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |-> (trap_addr == $past(csr_addr)));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_pulse |-> ($stable(trap_cause) && $stable(trap_addr)));

endmodule

bind csr_access_guard csr_access_guard_chk #(
  .CAUSE_W      (CAUSE_W),
  .ILLEGAL_CODE (ILLEGAL_CODE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .csr_addr   (csr_addr),
  .rd_en      (rd_en),
  .wr_en      (wr_en),
  .dbg_mode   (dbg_mode),
  .access_ok  (access_ok),
  .trap_pulse (trap_pulse),
  .trap_cause (trap_cause),
  .trap_addr  (trap_addr),
  .rd_bad     (rd_bad),
  .wr_bad     (wr_bad)
);

// File: tb/test_csr_access_guard.sv
`timescale 1ns/1ps
module test_csr_access_guard;

  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   csr_addr = '0;
  logic          rd_en = 1'b0;
  logic          wr_en = 1'b0;
  logic          dbg_mode = 1'b0;
  logic          access_ok;
  logic          trap_pulse;
  logic [CW-1:0] trap_cause;
  logic [11:0]   trap_addr;

  int  n_vec  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  csr_access_guard #(.CAUSE_W(CW)) i_csr_access_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .csr_addr   (csr_addr),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .dbg_mode   (dbg_mode),
    .access_ok  (access_ok),
    .trap_pulse (trap_pulse),
    .trap_cause (trap_cause),
    .trap_addr  (trap_addr)
  );

  task automatic chk(input bit good, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One access; checks combinational accept, then the registered trap outputs
  task automatic probe(input logic [11:0] a, input logic r, input logic w,
                       input logic d, input logic exp_ok, input string req);
    logic [11:0] prev_addr;
    logic [CW-1:0] prev_cause;
    @(negedge clk);
    prev_addr  = trap_addr;
    prev_cause = trap_cause;
    csr_addr = a; rd_en = r; wr_en = w; dbg_mode = d;
    #1;
    chk(access_ok === exp_ok, req, $sformatf("access_ok @%03h", a),
        32'(access_ok), 32'(exp_ok));
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0; dbg_mode = 1'b0;
    chk(trap_pulse === ~exp_ok, req, $sformatf("trap_pulse @%03h", a),
        32'(trap_pulse), 32'(~exp_ok));
    if (!exp_ok) begin
      chk(trap_cause === CW'(2), req, "trap_cause", 32'(trap_cause), 32'd2);
      chk(trap_addr === a, req, "trap_addr", 32'(trap_addr), 32'(a));
    end else begin
      chk(trap_addr === prev_addr && trap_cause === prev_cause, req,
          "capture held", 32'(trap_addr), 32'(prev_addr));
    end
    @(negedge clk);
    chk(trap_pulse === 1'b0, "R10", "pulse length", 32'(trap_pulse), 32'd0);
  endtask

  task automatic t_reset_state;
    chk(trap_pulse === 1'b0, "R11", "reset pulse", 32'(trap_pulse), 32'd0);
    chk(trap_cause === '0, "R11", "reset cause", 32'(trap_cause), 32'd0);
    chk(trap_addr === '0, "R11", "reset addr", 32'(trap_addr), 32'd0);
    chk(access_ok === 1'b0, "R10", "idle accept", 32'(access_ok), 32'd0);
  endtask

  task automatic t_ident;
    for (int k = 12'hF11; k <= 12'hF15; k++) begin
      probe(12'(k), 1'b1, 1'b0, 1'b0, 1'b1, "R1");
      probe(12'(k), 1'b0, 1'b1, 1'b0, 1'b0, "R1");
    end
  endtask

  task automatic t_shadow;
    logic [11:0] lst [4] = '{12'hC00, 12'hC02, 12'hC80, 12'hC82};
    foreach (lst[k]) begin
      probe(lst[k], 1'b1, 1'b0, 1'b0, 1'b1, "R2");
      probe(lst[k], 1'b0, 1'b1, 1'b0, 1'b0, "R2");
    end
  endtask

  task automatic t_trigger_deleg;
    probe(12'h7A0, 1'b1, 1'b0, 1'b0, 1'b1, "R3");
    probe(12'h7A0, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    probe(12'h7A1, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    probe(12'h7A1, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    probe(12'h302, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    probe(12'h302, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    probe(12'h303, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    probe(12'h303, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
  endtask

  task automatic t_machine;
    logic [11:0] lst [12] = '{12'h300, 12'h301, 12'h304, 12'h305, 12'h310, 12'h320,
                              12'h323, 12'h340, 12'h341, 12'h342, 12'h343, 12'h344};
    foreach (lst[k]) begin
      probe(lst[k], 1'b1, 1'b0, 1'b0, 1'b1, "R4");
      probe(lst[k], 1'b0, 1'b1, 1'b0, 1'b1, "R4");
    end
  endtask

  task automatic t_counters;
    logic [11:0] lst [4] = '{12'hB00, 12'hB02, 12'hB80, 12'hB82};
    foreach (lst[k]) begin
      probe(lst[k], 1'b1, 1'b0, 1'b0, 1'b1, "R5");
      probe(lst[k], 1'b0, 1'b1, 1'b0, 1'b1, "R5");
    end
    for (int n = 3; n <= 31; n++) begin
      probe(12'hB00 + 12'(n), 1'b0, 1'b1, 1'b0, 1'b1, "R5");
      probe(12'hB80 + 12'(n), 1'b1, 1'b0, 1'b0, 1'b1, "R5");
    end
  endtask

  task automatic t_debug;
    logic [11:0] lst [3] = '{12'h7B0, 12'h7B1, 12'hBFF};
    foreach (lst[k]) begin
      probe(lst[k], 1'b1, 1'b0, 1'b0, 1'b0, "R6");
      probe(lst[k], 1'b0, 1'b1, 1'b0, 1'b0, "R6");
      probe(lst[k], 1'b1, 1'b0, 1'b1, 1'b1, "R6");
      probe(lst[k], 1'b0, 1'b1, 1'b1, 1'b1, "R6");
    end
  endtask

  task automatic t_dscratch;
    for (int k = 12'h7B2; k <= 12'h7B3; k++) begin
      for (int d = 0; d < 2; d++) begin
        probe(12'(k), 1'b1, 1'b0, 1'(d), 1'b0, "R7");
        probe(12'(k), 1'b0, 1'b1, 1'(d), 1'b0, "R7");
      end
    end
  endtask

  task automatic t_unlisted;
    logic [11:0] lst [10] = '{12'h000, 12'h306, 12'h324, 12'h7A2, 12'hB01,
                              12'hB20, 12'hC01, 12'hF10, 12'hF16, 12'hFFF};
    foreach (lst[k]) begin
      probe(lst[k], 1'b1, 1'b0, 1'b0, 1'b0, "R8");
      probe(lst[k], 1'b0, 1'b1, 1'b1, 1'b0, "R8");
    end
  endtask

  task automatic t_both;
    probe(12'hF12, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
    probe(12'h7A0, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
    probe(12'h342, 1'b1, 1'b1, 1'b0, 1'b1, "R9");
    probe(12'h7B1, 1'b1, 1'b1, 1'b1, 1'b1, "R9");
  endtask

  task automatic t_idle;
    @(negedge clk);
    csr_addr = 12'hF11; rd_en = 1'b0; wr_en = 1'b0;
    #1;
    chk(access_ok === 1'b0, "R10", "no strobe accept", 32'(access_ok), 32'd0);
    @(negedge clk);
    chk(trap_pulse === 1'b0, "R10", "no strobe pulse", 32'(trap_pulse), 32'd0);
  endtask

  task automatic t_hold_reset;
    probe(12'h7A1, 1'b1, 1'b0, 1'b0, 1'b0, "R11");
    probe(12'h300, 1'b1, 1'b1, 1'b0, 1'b1, "R11");
    probe(12'hB05, 1'b0, 1'b1, 1'b0, 1'b1, "R11");
    chk(trap_addr === 12'h7A1, "R11", "addr held", 32'(trap_addr), 32'h7A1);
    chk(trap_cause === CW'(2), "R11", "cause held", 32'(trap_cause), 32'd2);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(trap_addr === '0, "R11", "reset clears addr", 32'(trap_addr), 32'd0);
    chk(trap_cause === '0, "R11", "reset clears cause", 32'(trap_cause), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_ident();
    t_shadow();
    t_trigger_deleg();
    t_machine();
    t_counters();
    t_debug();
    t_dscratch();
    t_unlisted();
    t_both();
    t_idle();
    t_hold_reset();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_fail++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule